// File: doc/BRIEF.md
# Snooping Copyback Data Cache Controller

This block holds the tags, line states and control sequencing for a 4 KB physically addressed data cache. The cache has four ways of 64 sets, and each line is 16 bytes. It serves processor loads and stores. Each store follows a per-access page mode: copyback or write-through. Lines are filled and written back by four-longword bursts over a simple request/done bus port. The block also watches the external bus for cycles from other masters and keeps the cached copies coherent with memory. The data array, bus timing and address translation sit outside the block.

A line is invalid, valid or dirty. A copyback store that hits makes its line dirty. A write-through store always goes to memory as a single word. A write-through store that misses allocates nothing. A read miss or a copyback store miss allocates a line. If the chosen victim is dirty, it is pushed out before the refill. A snoop is examined in the cycle it arrives and always takes that cycle away from the processor.

The controller has five states:
- IDLE: looks up the processor request.
- PUSH: burst write-back of a dirty victim.
- FILL: burst refill.
- INSTALL: writes the new tag and state, then acknowledges.
- WORD: single-word write-through.

The transitions are:
- IDLE→WORD on any write-through store.
- IDLE→PUSH on an allocating miss whose victim is dirty.
- IDLE→FILL on an allocating miss whose victim is clean.
- PUSH→FILL on bus done.
- FILL→INSTALL on bus done.
- INSTALL→IDLE on the first cycle with no snoop.
- WORD→IDLE on bus done.
- Every other case holds the state.

Top module: `snoop_dcache_ctrl`

## Requirements
- R1: An address splits into bits 3:0 (byte in line), bits 9:4 (set, 64 sets) and bits 31:10 (tag). Burst bus addresses carry the line address with bits 3:0 zero.
- R2: After reset every line is invalid, and cpu_ack, bus_req, snp_supply and icache_inval are low.
- R3: A processor read that hits asserts cpu_ack in the request cycle, with no bus request, when no snoop is present.
- R4: A read miss, or a copyback store miss, requests a fill burst (bus_cmd 1) at the line address. It then installs the line, as dirty for a store and valid for a read, and acknowledges in the cycle after bus_done.
- R5: The victim is the lowest-numbered invalid way of the set. If no way is invalid, the victim is the way named by that set's round-robin pointer. The pointer starts at 0 and steps by one, modulo 4, on every allocation in the set.
- R6: A dirty victim is first written back by a push burst (bus_cmd 2) at the victim's line address, and the fill follows it.
- R7: A write-through store issues one word write (bus_cmd 3) at the full address and acknowledges in the bus_done cycle. On a hit the line state is unchanged, and on a miss no line is allocated.
- R8: A copyback store that hits acknowledges in the request cycle, with no bus request, and leaves the line dirty.
- R9: A snoopable external write invalidates any matching line and raises icache_inval for one cycle, in the cycle after the snoop.
- R10: A snoopable external read that hits a dirty line raises snp_supply in the cycle after the snoop and leaves the line valid. A read that hits a valid line changes nothing.
- R11: A snoop with snp_snoopable low has no effect on the lines or on the snoop outputs.
- R12: A snoop in the same cycle as a processor lookup or install is served first. The processor step is deferred by one cycle and sees the updated line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ack |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_copyback | input | 1 | Page mode: 1 = copyback, 0 = write-through |
| cpu_addr | input | 32 | Physical byte address |
| cpu_ack | output | 1 | Access complete |
| bus_req | output | 1 | Bus transfer requested |
| bus_cmd | output | 2 | 1 fill burst, 2 push burst, 3 single word write |
| bus_addr | output | 32 | Line address for bursts, byte address for word writes |
| bus_done | input | 1 | Current transfer finished (one-cycle pulse) |
| snp_valid | input | 1 | External bus cycle present |
| snp_snoopable | input | 1 | External cycle is marked snoopable |
| snp_write | input | 1 | External cycle is a write |
| snp_addr | input | 32 | External cycle address |
| snp_supply | output | 1 | Dirty line must supply data to the external read |
| icache_inval | output | 1 | Instruction cache must invalidate the snooped address |

## Verification
The functions that can fall in the same cycle are a snoop and a processor tag lookup or install. Both want the tag store's single write port and may touch the same line. The bench provokes this by raising a snoopable read or write on the very cycle a processor request arrives, often aimed at the line that request hits. It checks that no acknowledge appears in that cycle. It also checks that the deferred access sees the post-snoop state: an invalidated line now misses and refills, and a cleaned line is evicted without a push. A reference model of tags, states and pointers predicts every bus transfer and snoop output.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    typedef enum logic [1:0] {
        LN_INV   = 2'd0,
        LN_VALID = 2'd1,
        LN_DIRTY = 2'd2
    } line_state_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_FILL,
        ST_INSTALL,
        ST_WORD
    } ctrl_state_t;

    localparam logic [1:0] CMD_NONE = 2'd0;
    localparam logic [1:0] CMD_FILL = 2'd1;
    localparam logic [1:0] CMD_PUSH = 2'd2;
    localparam logic [1:0] CMD_WORD = 2'd3;
endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store
    import dcache_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int TAG_W = 22
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  cpu_set,
    input  logic [TAG_W-1:0]         cpu_tag,
    output logic                     cpu_hit,
    output logic [$clog2(WAYS)-1:0]  cpu_way,
    output logic [TAG_W-1:0]         row_tag   [WAYS],
    output line_state_t              row_state [WAYS],
    input  logic [$clog2(SETS)-1:0]  snp_set,
    input  logic [TAG_W-1:0]         snp_tag,
    output logic                     snp_hit,
    output logic [$clog2(WAYS)-1:0]  snp_way,
    output line_state_t              snp_state,
    input  logic                     wr_en,
    input  logic [$clog2(SETS)-1:0]  wr_set,
    input  logic [$clog2(WAYS)-1:0]  wr_way,
    input  logic [TAG_W-1:0]         wr_tag,
    input  line_state_t              wr_state
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int LINES = SETS * WAYS;

    logic [TAG_W-1:0] tag_q [LINES];
    line_state_t      st_q  [LINES];
    logic [WAYS-1:0]  cpu_match;
    logic [WAYS-1:0]  snp_match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
        end else if (wr_en) begin
            st_q[{wr_set, wr_way}] <= wr_state;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[{wr_set, wr_way}] <= wr_tag;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign row_tag[w]   = tag_q[{cpu_set, WAY_W'(w)}];
        assign row_state[w] = st_q[{cpu_set, WAY_W'(w)}];
        assign cpu_match[w] = (row_state[w] != LN_INV) && (row_tag[w] == cpu_tag);
        assign snp_match[w] = (st_q[{snp_set, WAY_W'(w)}] != LN_INV)
                              && (tag_q[{snp_set, WAY_W'(w)}] == snp_tag);
    end

    always_comb begin
        cpu_way = '0;
        snp_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (cpu_match[w]) cpu_way = WAY_W'(w);
            if (snp_match[w]) snp_way = WAY_W'(w);
        end
    end

    assign cpu_hit   = |cpu_match;
    assign snp_hit   = |snp_match;
    assign snp_state = st_q[{snp_set, snp_way}];

    // R5: allocation never leaves two live copies of one line in a set
    a_r5_single_cpu_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_match));
    a_r5_single_snp_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(snp_match));
endmodule

// File: rtl/dcache_victim.sv
module dcache_victim #(
    parameter int SETS = 64,
    parameter int WAYS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] sel_set,
    input  logic [WAYS-1:0]         row_valid,
    input  logic                    adv_en,
    input  logic [$clog2(SETS)-1:0] adv_set,
    output logic [$clog2(WAYS)-1:0] victim_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] ptr_q [SETS];
    logic             found;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (adv_en) begin
            ptr_q[adv_set] <= ptr_q[adv_set] + 1'b1;
        end
    end

    always_comb begin
        victim_way = ptr_q[sel_set];
        found      = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !row_valid[w]) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
    end

    // R5: a free way is always preferred over the round-robin choice
    a_r5_free_way_first: assert property (@(posedge clk) disable iff (!rst_n)
        (~row_valid != '0) |-> !row_valid[victim_way]);
endmodule

// File: rtl/snoop_dcache_ctrl.sv
module snoop_dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int SETS       = 64,
    parameter int WAYS       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_copyback,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ack,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_done,
    input  logic              snp_valid,
    input  logic              snp_snoopable,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_supply,
    output logic              icache_inval
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - OFF_W - SET_W;

    ctrl_state_t state_q, state_d;

    logic [SET_W-1:0]  cpu_set, snp_set, miss_set_q;
    logic [TAG_W-1:0]  cpu_tag, snp_tag, miss_tag_q, vic_tag_q;
    logic [WAY_W-1:0]  cpu_way, snp_way, victim_way, vic_way_q;
    logic              cpu_hit, snp_hit, miss_we_q;
    logic [ADDR_W-1:0] word_addr_q;
    logic [TAG_W-1:0]  row_tag   [WAYS];
    line_state_t       row_state [WAYS];
    line_state_t       snp_state;
    logic [WAYS-1:0]   row_valid;
    logic              unused_snp_off;

    logic              cpu_go, snoop_act;
    logic              cpu_wr_en, adv_en;
    logic [SET_W-1:0]  cpu_wr_set;
    logic [WAY_W-1:0]  cpu_wr_way;
    logic [TAG_W-1:0]  cpu_wr_tag;
    line_state_t       cpu_wr_state;
    logic              wr_en;
    logic [SET_W-1:0]  wr_set;
    logic [WAY_W-1:0]  wr_way;
    logic [TAG_W-1:0]  wr_tag;
    line_state_t       wr_state;

    assign cpu_set        = cpu_addr[OFF_W +: SET_W];
    assign cpu_tag        = cpu_addr[ADDR_W-1 -: TAG_W];
    assign snp_set        = snp_addr[OFF_W +: SET_W];
    assign snp_tag        = snp_addr[ADDR_W-1 -: TAG_W];
    assign unused_snp_off = ^snp_addr[OFF_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_valid
        assign row_valid[w] = (row_state[w] != LN_INV);
    end

    dcache_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cpu_set(cpu_set), .cpu_tag(cpu_tag), .cpu_hit(cpu_hit), .cpu_way(cpu_way),
        .row_tag(row_tag), .row_state(row_state),
        .snp_set(snp_set), .snp_tag(snp_tag), .snp_hit(snp_hit), .snp_way(snp_way),
        .snp_state(snp_state),
        .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_tag(wr_tag), .wr_state(wr_state)
    );

    dcache_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .sel_set(cpu_set), .row_valid(row_valid),
        .adv_en(adv_en), .adv_set(miss_set_q),
        .victim_way(victim_way)
    );

    // Snoop owns the cycle whenever it is present (R12)
    assign cpu_go    = (state_q == ST_IDLE) && cpu_req && !snp_valid;
    assign snoop_act = snp_valid && snp_snoopable && snp_hit
                       && (snp_write || (snp_state == LN_DIRTY));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_go) begin
                    if (cpu_we && !cpu_copyback)            state_d = ST_WORD;
                    else if (!cpu_hit)
                        state_d = (row_state[victim_way] == LN_DIRTY) ? ST_PUSH : ST_FILL;
                end
            end
            ST_PUSH:    if (bus_done)   state_d = ST_FILL;
            ST_FILL:    if (bus_done)   state_d = ST_INSTALL;
            ST_INSTALL: if (!snp_valid) state_d = ST_IDLE;
            ST_WORD:    if (bus_done)   state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_ack      = 1'b0;
        bus_req      = 1'b0;
        bus_cmd      = CMD_NONE;
        bus_addr     = '0;
        cpu_wr_en    = 1'b0;
        cpu_wr_set   = cpu_set;
        cpu_wr_way   = cpu_way;
        cpu_wr_tag   = cpu_tag;
        cpu_wr_state = LN_DIRTY;
        adv_en       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_go && cpu_hit) begin
                    if (!cpu_we) begin
                        cpu_ack = 1'b1;
                    end else if (cpu_copyback) begin
                        cpu_ack   = 1'b1;
                        cpu_wr_en = 1'b1;
                    end
                end
            end
            ST_PUSH: begin
                bus_req  = 1'b1;
                bus_cmd  = CMD_PUSH;
                bus_addr = {vic_tag_q, miss_set_q, {OFF_W{1'b0}}};
            end
            ST_FILL: begin
                bus_req  = 1'b1;
                bus_cmd  = CMD_FILL;
                bus_addr = {miss_tag_q, miss_set_q, {OFF_W{1'b0}}};
            end
            ST_INSTALL: begin
                if (!snp_valid) begin
                    cpu_ack      = 1'b1;
                    cpu_wr_en    = 1'b1;
                    cpu_wr_set   = miss_set_q;
                    cpu_wr_way   = vic_way_q;
                    cpu_wr_tag   = miss_tag_q;
                    cpu_wr_state = miss_we_q ? LN_DIRTY : LN_VALID;
                    adv_en       = 1'b1;
                end
            end
            ST_WORD: begin
                bus_req  = 1'b1;
                bus_cmd  = CMD_WORD;
                bus_addr = word_addr_q;
                cpu_ack  = bus_done;
            end
            default: ;
        endcase
    end

    // Single tag-store write port: snoop update wins
    assign wr_en    = snoop_act || cpu_wr_en;
    assign wr_set   = snoop_act ? snp_set : cpu_wr_set;
    assign wr_way   = snoop_act ? snp_way : cpu_wr_way;
    assign wr_tag   = snoop_act ? snp_tag : cpu_wr_tag;
    assign wr_state = snoop_act ? (snp_write ? LN_INV : LN_VALID) : cpu_wr_state;

    always_ff @(posedge clk) begin
        if (cpu_go) begin
            miss_set_q  <= cpu_set;
            miss_tag_q  <= cpu_tag;
            vic_way_q   <= victim_way;
            vic_tag_q   <= row_tag[victim_way];
            miss_we_q   <= cpu_we;
            word_addr_q <= cpu_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snp_supply   <= 1'b0;
            icache_inval <= 1'b0;
        end else begin
            snp_supply   <= snp_valid && snp_snoopable && !snp_write && snp_hit
                            && (snp_state == LN_DIRTY);
            icache_inval <= snp_valid && snp_snoopable && snp_write;
        end
    end

    a_r12_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && state_q != ST_WORD) |-> !cpu_ack);
    a_r11_not_snoopable: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_snoopable) |=> (!snp_supply && !icache_inval));
    a_r6_push_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == CMD_PUSH && bus_done) |=> (bus_req && bus_cmd == CMD_FILL));
    a_r1_burst_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd != CMD_WORD) |-> (bus_addr[OFF_W-1:0] == '0));
    a_r7_word_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == CMD_WORD && !bus_done) |=> $stable(bus_addr));
endmodule

// File: tb/tb_snoop_dcache_ctrl.sv
`timescale 1ns/1ps
module tb_snoop_dcache_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we, cpu_copyback;
    logic [31:0] cpu_addr;
    logic        cpu_ack;
    logic        bus_req;
    logic [1:0]  bus_cmd;
    logic [31:0] bus_addr;
    logic        bus_done;
    logic        snp_valid, snp_snoopable, snp_write;
    logic [31:0] snp_addr;
    logic        snp_supply, icache_inval;

    always #4 clk = ~clk;

    snoop_dcache_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_copyback(cpu_copyback),
        .cpu_addr(cpu_addr), .cpu_ack(cpu_ack),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_done(bus_done),
        .snp_valid(snp_valid), .snp_snoopable(snp_snoopable), .snp_write(snp_write),
        .snp_addr(snp_addr), .snp_supply(snp_supply), .icache_inval(icache_inval)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model: state 0 invalid, 1 valid, 2 dirty
    int m_tag [64][4];
    int m_st  [64][4];
    int m_ptr [64];

    int          e_n;
    logic [1:0]  e_cmd  [4];
    logic [31:0] e_addr [4];
    string       e_req;

    int          lg_n;
    logic [1:0]  lg_cmd  [4];
    logic [31:0] lg_addr [4];

    logic [31:0] rng = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int tag, input int set, input int off);
        logic [21:0] t = tag[21:0];
        logic [5:0]  s = set[5:0];
        logic [3:0]  o = off[3:0];
        return {t, s, o};
    endfunction

    function automatic int m_find(input int s, input int t);
        for (int w = 0; w < 4; w++)
            if (m_st[s][w] != 0 && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    task automatic m_snoop(input logic [31:0] a, input bit snoopable, input bit wr,
                           output bit e_sup, output bit e_inv);
        int s = int'(a[9:4]);
        int t = int'(a[31:10]);
        int w = m_find(s, t);
        e_sup = 0;
        e_inv = 0;
        if (snoopable) begin
            if (wr) begin
                e_inv = 1;
                if (w >= 0) m_st[s][w] = 0;
            end else if (w >= 0 && m_st[s][w] == 2) begin
                e_sup = 1;
                m_st[s][w] = 1;
            end
        end
    endtask

    task automatic m_access(input logic [31:0] a, input bit we, input bit cb);
        int s = int'(a[9:4]);
        int t = int'(a[31:10]);
        int w = m_find(s, t);
        int v = -1;
        e_n = 0;
        if (we && !cb) begin
            e_req = "R7";
            e_cmd[0] = 2'd3; e_addr[0] = a; e_n = 1;
        end else if (w >= 0) begin
            e_req = we ? "R8" : "R3";
            if (we) m_st[s][w] = 2;
        end else begin
            e_req = "R4";
            for (int k = 0; k < 4; k++) if (v < 0 && m_st[s][k] == 0) v = k;
            if (v < 0) begin v = m_ptr[s]; e_req = "R5"; end
            if (m_st[s][v] == 2) begin
                e_req = "R6";
                e_cmd[e_n] = 2'd2; e_addr[e_n] = mk_addr(m_tag[s][v], s, 0); e_n++;
            end
            e_cmd[e_n] = 2'd1; e_addr[e_n] = mk_addr(t, s, 0); e_n++;
            m_tag[s][v] = t;
            m_st[s][v]  = we ? 2 : 1;
            m_ptr[s]    = (m_ptr[s] + 1) % 4;
        end
    endtask

    task automatic do_access(input logic [31:0] a, input bit we, input bit cb,
                             input bit coll, input logic [31:0] sa, input bit swr);
        bit e_sup = 0, e_inv = 0, got_sup = 0, got_inv = 0;
        int ack_at = -1;
        int lat = 0;
        if (coll) m_snoop(sa, 1'b1, swr, e_sup, e_inv);
        m_access(a, we, cb);
        lg_n = 0;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_copyback = cb; cpu_addr = a;
        if (coll) begin
            snp_valid = 1; snp_snoopable = 1; snp_write = swr; snp_addr = sa;
        end
        for (int c = 0; c < 80; c++) begin
            bus_done = 0;
            if (c > 0) snp_valid = 0;
            #1;
            if (c == 1) begin got_sup = snp_supply; got_inv = icache_inval; end
            if (bus_req) begin
                lat++;
                if (lat == 3) begin
                    bus_done = 1;
                    lat = 0;
                    if (lg_n < 4) begin lg_cmd[lg_n] = bus_cmd; lg_addr[lg_n] = bus_addr; end
                    lg_n++;
                end
            end
            #1;
            if (cpu_ack) ack_at = c;
            @(posedge clk);
            @(negedge clk);
            if (ack_at >= 0) break;
        end
        cpu_req = 0; bus_done = 0; snp_valid = 0;
        chk(ack_at >= 0, e_req, "access acknowledged", ack_at, 0);
        chk(lg_n == e_n, e_req, "bus transfer count", lg_n, e_n);
        for (int i = 0; i < e_n && i < lg_n && i < 4; i++) begin
            chk(lg_cmd[i] == e_cmd[i], e_req, "bus command", lg_cmd[i], e_cmd[i]);
            chk(lg_addr[i] == e_addr[i], "R1", "bus address", lg_addr[i], e_addr[i]);
        end
        if (e_n == 0) chk(ack_at == (coll ? 1 : 0), e_req, "hit ack cycle", ack_at, coll ? 1 : 0);
        if (coll) begin
            chk(got_sup == e_sup, "R12", "collision snp_supply", got_sup, e_sup);
            chk(got_inv == e_inv, "R12", "collision icache_inval", got_inv, e_inv);
            chk(ack_at >= 1, "R12", "no ack in snoop cycle", ack_at, 1);
        end
    endtask

    task automatic do_snoop(input logic [31:0] a, input bit snoopable, input bit wr);
        bit e_sup, e_inv;
        string rq;
        m_snoop(a, snoopable, wr, e_sup, e_inv);
        rq = !snoopable ? "R11" : (wr ? "R9" : "R10");
        @(negedge clk);
        snp_valid = 1; snp_snoopable = snoopable; snp_write = wr; snp_addr = a;
        @(negedge clk);
        snp_valid = 0;
        #1;
        chk(snp_supply == e_sup, rq, "snp_supply", snp_supply, e_sup);
        chk(icache_inval == e_inv, rq, "icache_inval", icache_inval, e_inv);
        @(negedge clk);
        #1;
        chk(!snp_supply && !icache_inval, rq, "snoop outputs one cycle", {snp_supply, icache_inval}, 0);
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13;
        y ^= y >> 17;
        y ^= y << 5;
        return y;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int sets [3] = '{0, 1, 63};
        for (int s = 0; s < 64; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < 4; w++) begin m_st[s][w] = 0; m_tag[s][w] = 0; end
        end
        rst_n = 0;
        cpu_req = 0; cpu_we = 0; cpu_copyback = 0; cpu_addr = 0; bus_done = 0;
        snp_valid = 0; snp_snoopable = 0; snp_write = 0; snp_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!cpu_ack && !bus_req && !snp_supply && !icache_inval, "R2", "outputs in reset",
            {cpu_ack, bus_req, snp_supply, icache_inval}, 0);
        rst_n = 1;

        // R2, R4, R5: fill and evict reads across three sets, tag bit 21 varied (R1)
        foreach (sets[i]) begin
            for (int t = 0; t < 6; t++) do_access(mk_addr(t | ((t & 1) << 21), sets[i], t), 0, 1, 0, 0, 0);
            for (int t = 0; t < 6; t++) do_access(mk_addr(t | ((t & 1) << 21), sets[i], 4), 0, 1, 0, 0, 0);
        end

        // R6, R8: copyback stores with dirty evictions
        for (int t = 0; t < 7; t++) do_access(mk_addr(t + 16, 2, 0), 1, 1, 0, 0, 0);
        for (int t = 0; t < 7; t++) do_access(mk_addr(t + 16, 2, 8), 1, 1, 0, 0, 0);

        // R7: write-through hit then miss; miss leaves set untouched
        do_access(mk_addr(40, 3, 0), 0, 1, 0, 0, 0);
        do_access(mk_addr(40, 3, 12), 1, 0, 0, 0, 0);
        do_access(mk_addr(41, 3, 4), 1, 0, 0, 0, 0);
        do_access(mk_addr(41, 3, 4), 0, 1, 0, 0, 0);
        do_access(mk_addr(40, 3, 0), 0, 1, 0, 0, 0);

        // R9, R10, R11: snoops then re-access
        do_access(mk_addr(50, 4, 0), 1, 1, 0, 0, 0);
        do_snoop(mk_addr(50, 4, 0), 0, 1);
        do_access(mk_addr(50, 4, 0), 0, 1, 0, 0, 0);   // R11: still a hit
        do_snoop(mk_addr(50, 4, 0), 0, 0);
        do_snoop(mk_addr(50, 4, 0), 1, 0);              // dirty -> supply
        do_snoop(mk_addr(50, 4, 0), 1, 0);              // now valid -> nothing
        do_snoop(mk_addr(50, 4, 0), 1, 1);              // invalidate
        do_access(mk_addr(50, 4, 0), 0, 1, 0, 0, 0);   // refill
        do_snoop(mk_addr(99, 4, 0), 1, 1);              // miss write still flags icache

        // R10: cleaned line evicts without push
        for (int t = 0; t < 4; t++) do_access(mk_addr(60 + t, 5, 0), 1, 1, 0, 0, 0);
        do_snoop(mk_addr(60, 5, 0), 1, 0);
        do_access(mk_addr(70, 5, 0), 0, 1, 0, 0, 0);

        // R12: collisions on the same line
        do_access(mk_addr(80, 6, 0), 1, 1, 0, 0, 0);
        do_access(mk_addr(80, 6, 0), 0, 1, 1, mk_addr(80, 6, 0), 1);
        do_access(mk_addr(80, 6, 0), 1, 1, 0, 0, 0);
        do_access(mk_addr(80, 6, 0), 1, 1, 1, mk_addr(80, 6, 0), 0);

        // near-exhaustive mixed traffic over a small address pool
        for (int n = 0; n < 500; n++) begin
            logic [31:0] a, sa;
            rng = next_rng(rng);
            a  = mk_addr(int'(rng[2:0]) % 6 + (rng[3] ? 32'h20_0000 : 0), rng[4] ? 7 : 8, int'(rng[7:4]));
            sa = mk_addr(int'(rng[18:16]) % 6 + (rng[19] ? 32'h20_0000 : 0), rng[20] ? 7 : 8, 0);
            if (rng[25:24] == 2'd0)
                do_snoop(sa, rng[26], rng[27]);
            else
                do_access(a, rng[8], rng[9] | rng[10], rng[28] & rng[29], sa, rng[27]);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule